// File: doc/BRIEF.md
# Protection Information Tuple Checker

This block verifies end-to-end protection information on a stream of logical blocks, one byte per accepted cycle. Each block consists of a fixed number of data bytes followed by a fixed number of metadata bytes. An 8-byte protection tuple sits inside the metadata, either at its start or at its end. The tuple holds a 16-bit guard, a 16-bit application tag and a 32-bit reference tag, each stored most significant byte first.

A command is opened with a start pulse. The pulse carries the protection type, three check-enable bits, the expected application tag and its mask, the starting reference tag, the low 32 bits of the starting block address, the tuple placement and the block count. The block first screens the reference-tag settings. It then checks each block as its last byte arrives and reports one status per command with a single done pulse. Once a command has failed, its remaining bytes are consumed without being checked.

Top module: `pi_tuple_checker`

## Requirements
- R1: When a command starts with type 1 (prot_type_i=1) and reference checking enabled, and slba_i differs from ref_tag_i, the command ends with status 4 (invalid protection info) and dnr_o=1. No block is examined.
- R2: When a command starts with type 3 (prot_type_i=3) and reference checking enabled, the command ends with status 4 and dnr_o=0.
- R3: For types 1 and 2, a block whose stored application tag is 0xFFFF passes, whatever its guard and reference tag hold.
- R4: For type 3, a block is skipped only when the stored application tag is 0xFFFF and the stored reference tag is 0xFFFFFFFF. An application tag of 0xFFFF on its own does not skip the checks.
- R5: The enabled checks are applied in the order guard, then application tag, then reference tag. The first failure ends the command with status 1 (guard), 2 (application tag) or 3 (reference tag).
- R6: The application tag check compares (stored AND app_mask_i) with (app_tag_i AND app_mask_i). Bits outside the mask never cause a failure.
- R7: For types 1 and 2, the expected reference tag is ref_tag_i for the first block and increases by one for each block after it. For type 3 it stays fixed.
- R8: The guard is a CRC-16 with polynomial 0x8BB7, initial value 0, processed MSB first with no reflection and no final XOR. It covers the data bytes, plus the metadata bytes ahead of the tuple when tuple_last_i=1. The tuple takes the last 8 metadata bytes when tuple_last_i=1 and the first 8 when tuple_last_i=0. Its byte order is guard, then application tag, then reference tag, each big-endian.
- R9: done_o is high for exactly one cycle per command. status_o and dnr_o are valid from that cycle and hold until the next done. A command in which every block passes reports status 0 after its final block.
- R10: After an error, the rest of the command's bytes are consumed without producing another done. Bytes presented while no command is open are ignored.
- R11: Check-enable bit 2 enables the guard check, bit 1 the application tag check and bit 0 the reference tag check. A disabled check never causes a failure.
- R12: done_o rises in the cycle after the clock edge that accepts the start (pre-check failure) or the last byte of the deciding block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a command; accepted only when no command is open |
| prot_type_i | input | 2 | Protection type 1, 2 or 3 |
| chk_en_i | input | 3 | Check enables: [2] guard, [1] application tag, [0] reference tag |
| tuple_last_i | input | 1 | 1: tuple at end of metadata; 0: tuple at start |
| app_tag_i | input | 16 | Expected application tag |
| app_mask_i | input | 16 | Application tag compare mask |
| ref_tag_i | input | 32 | Starting expected reference tag |
| slba_i | input | 32 | Low 32 bits of the starting block address |
| num_blk_i | input | NB_W | Block count minus one |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_i | input | 8 | Stream byte |
| done_o | output | 1 | One-cycle command completion pulse |
| status_o | output | 3 | 0 ok, 1 guard, 2 app tag, 3 ref tag, 4 invalid protection info |
| dnr_o | output | 1 | Do-not-retry flag for the last reported status |

## Verification
A failing pre-check makes the result visible right after the edge that accepts the start. A block verdict becomes visible right after the edge that accepts that block's final metadata byte; no extra pipeline stage lies in either path. The bench drives each byte on the falling edge and samples done_o, status_o and dnr_o 1 ns after the following rising edge. It counts done pulses over the whole command, including idle gaps inserted into the stream, so a late, early or repeated done shows up as a wrong count or as a missing pulse at the expected byte.

// File: rtl/pi_pkg.sv
package pi_pkg;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_GUARD   = 3'd1,
    ST_APP     = 3'd2,
    ST_REF     = 3'd3,
    ST_INVALID = 3'd4
  } pi_status_e;

  localparam logic [1:0]  PT_TYPE1 = 2'd1;
  localparam logic [1:0]  PT_TYPE3 = 2'd3;
  localparam logic [15:0] CRC_POLY = 16'h8BB7;
  localparam int          TUPLE_BYTES = 8;

  typedef struct packed {
    logic [15:0] guard;
    logic [15:0] app;
    logic [31:0] rtag;
  } pi_tuple_t;

  function automatic logic [15:0] crc16_byte(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      if (c[15] ^ b[i]) c = {c[14:0], 1'b0} ^ CRC_POLY;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/pi_crc16.sv
module pi_crc16 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  import pi_pkg::*;

  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc16_byte(crc_q, byte_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/pi_block_pos.sv
module pi_block_pos #(
  parameter int DATA_BYTES = 16,
  parameter int META_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [7:0]        byte_i,
  input  logic              tuple_last_i,
  output logic              crc_byte_o,
  output logic              blk_end_o,
  output pi_pkg::pi_tuple_t tuple_o
);
  import pi_pkg::*;

  localparam int BLK_BYTES = DATA_BYTES + META_BYTES;
  localparam int PAD_BYTES = META_BYTES - TUPLE_BYTES;
  localparam int IDX_W     = $clog2(BLK_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(BLK_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_META  = IDX_W'(DATA_BYTES);
  localparam logic [IDX_W-1:0] IDX_PADND = IDX_W'(DATA_BYTES + PAD_BYTES);
  localparam logic [IDX_W-1:0] IDX_TUPND = IDX_W'(DATA_BYTES + TUPLE_BYTES);

  logic [IDX_W-1:0] idx_q;
  logic [63:0]      tup_q;
  logic             tup_byte;

  always_comb begin
    if (tuple_last_i) begin
      crc_byte_o = idx_q < IDX_PADND;
      tup_byte   = idx_q >= IDX_PADND;
    end else begin
      crc_byte_o = idx_q < IDX_META;
      tup_byte   = (idx_q >= IDX_META) && (idx_q < IDX_TUPND);
    end
  end

  assign blk_end_o = idx_q == IDX_LAST;
  assign tuple_o   = tup_byte ? {tup_q[55:0], byte_i} : tup_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      tup_q <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
    end else if (adv_i) begin
      idx_q <= blk_end_o ? '0 : idx_q + 1'b1;
      if (tup_byte) tup_q <= {tup_q[55:0], byte_i};
    end
  end

  // R8: the byte index never leaves the block
  p_idx_in_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_LAST);

endmodule

// File: rtl/pi_block_eval.sv
module pi_block_eval (
  input  logic [1:0]         typ_i,
  input  logic [2:0]         chk_en_i,
  input  logic [15:0]        exp_app_i,
  input  logic [15:0]        app_mask_i,
  input  logic [31:0]        exp_ref_i,
  input  logic [15:0]        crc_i,
  input  pi_pkg::pi_tuple_t  tuple_i,
  output pi_pkg::pi_status_e status_o
);
  import pi_pkg::*;

  logic escape;

  always_comb begin
    if (typ_i == PT_TYPE3) escape = (tuple_i.app == 16'hFFFF) && (tuple_i.rtag == 32'hFFFF_FFFF);
    else                   escape = tuple_i.app == 16'hFFFF;

    if (escape)
      status_o = ST_OK;
    else if (chk_en_i[2] && (tuple_i.guard != crc_i))
      status_o = ST_GUARD;
    else if (chk_en_i[1] && ((tuple_i.app & app_mask_i) != (exp_app_i & app_mask_i)))
      status_o = ST_APP;
    else if (chk_en_i[0] && (tuple_i.rtag != exp_ref_i))
      status_o = ST_REF;
    else
      status_o = ST_OK;
  end
endmodule

// File: rtl/pi_tuple_checker.sv
module pi_tuple_checker #(
  parameter int DATA_BYTES = 16,
  parameter int META_BYTES = 16,
  parameter int NB_W       = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      prot_type_i,
  input  logic [2:0]      chk_en_i,
  input  logic            tuple_last_i,
  input  logic [15:0]     app_tag_i,
  input  logic [15:0]     app_mask_i,
  input  logic [31:0]     ref_tag_i,
  input  logic [31:0]     slba_i,
  input  logic [NB_W-1:0] num_blk_i,
  input  logic            byte_valid_i,
  input  logic [7:0]      byte_i,
  output logic            done_o,
  output logic [2:0]      status_o,
  output logic            dnr_o
);
  import pi_pkg::*;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_e;

  state_e          state_q;
  logic [1:0]      typ_q;
  logic [2:0]      en_q;
  logic            last_q;
  logic [15:0]     app_q, mask_q;
  logic [31:0]     ref_q;
  logic [NB_W-1:0] left_q;
  logic            done_q, dnr_q;
  logic [2:0]      status_q;

  logic       start_ok, accept, blk_end, end_evt, cmd_end, crc_byte;
  logic       pre_bad;
  logic [15:0] crc;
  pi_tuple_t  tuple;
  pi_status_e blk_st;

  assign start_ok = start_i && (state_q == S_IDLE);
  assign accept   = byte_valid_i && (state_q != S_IDLE);
  assign end_evt  = accept && blk_end;
  assign cmd_end  = end_evt && (left_q == '0);
  assign pre_bad  = chk_en_i[0] && ((prot_type_i == PT_TYPE3) ||
                    ((prot_type_i == PT_TYPE1) && (slba_i != ref_tag_i)));

  pi_block_pos #(.DATA_BYTES(DATA_BYTES), .META_BYTES(META_BYTES)) u_pos (
    .clk_i, .rst_ni,
    .clr_i(start_ok), .adv_i(accept), .byte_i,
    .tuple_last_i(last_q),
    .crc_byte_o(crc_byte), .blk_end_o(blk_end), .tuple_o(tuple)
  );

  pi_crc16 u_crc (
    .clk_i, .rst_ni,
    .clr_i(start_ok || end_evt), .en_i(accept && crc_byte),
    .byte_i, .crc_o(crc)
  );

  pi_block_eval u_eval (
    .typ_i(typ_q), .chk_en_i(en_q), .exp_app_i(app_q), .app_mask_i(mask_q),
    .exp_ref_i(ref_q), .crc_i(crc), .tuple_i(tuple), .status_o(blk_st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      typ_q    <= '0;
      en_q     <= '0;
      last_q   <= 1'b0;
      app_q    <= '0;
      mask_q   <= '0;
      ref_q    <= '0;
      left_q   <= '0;
      done_q   <= 1'b0;
      status_q <= ST_OK;
      dnr_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          typ_q  <= prot_type_i;
          en_q   <= chk_en_i;
          last_q <= tuple_last_i;
          app_q  <= app_tag_i;
          mask_q <= app_mask_i;
          ref_q  <= ref_tag_i;
          left_q <= num_blk_i;
          if (pre_bad) begin
            done_q   <= 1'b1;
            status_q <= ST_INVALID;
            dnr_q    <= prot_type_i == PT_TYPE1;
            state_q  <= S_DRAIN;
          end else begin
            state_q  <= S_RUN;
          end
        end
        S_RUN: if (end_evt) begin
          if (blk_st != ST_OK) begin
            done_q   <= 1'b1;
            status_q <= blk_st;
            dnr_q    <= 1'b0;
            state_q  <= cmd_end ? S_IDLE : S_DRAIN;
            left_q   <= left_q - 1'b1;
          end else if (cmd_end) begin
            done_q   <= 1'b1;
            status_q <= ST_OK;
            dnr_q    <= 1'b0;
            state_q  <= S_IDLE;
          end else begin
            left_q   <= left_q - 1'b1;
            if (typ_q != PT_TYPE3) ref_q <= ref_q + 1'b1;
          end
        end
        S_DRAIN: if (end_evt) begin
          if (cmd_end) state_q <= S_IDLE;
          else         left_q  <= left_q - 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign status_o = status_q;
  assign dnr_o    = dnr_q;

  p_pre_type1_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && start_i && prot_type_i == PT_TYPE1 && chk_en_i[0] && slba_i != ref_tag_i)
    |=> (done_o && status_o == ST_INVALID && dnr_o));

  p_pre_type3_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && start_i && prot_type_i == PT_TYPE3 && chk_en_i[0])
    |=> (done_o && status_o == ST_INVALID && !dnr_o));

  p_ref_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RUN && end_evt && !cmd_end && blk_st == ST_OK && typ_q != PT_TYPE3)
    |=> (ref_q == $past(ref_q) + 32'd1));

  p_ref_fixed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && typ_q == PT_TYPE3) |=> $stable(ref_q));

  p_ok_closes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == ST_OK) |-> state_q == S_IDLE);

  p_quiet_drain_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DRAIN && $past(state_q) == S_DRAIN) |-> !done_o);

endmodule

// File: tb/pi_tuple_checker_test.sv
`timescale 1ns/1ps
module pi_tuple_checker_test;

  localparam int DATA_BYTES = 16;
  localparam int META_BYTES = 16;
  localparam int PAD        = META_BYTES - 8;
  localparam int BLK        = DATA_BYTES + META_BYTES;

  typedef struct packed {
    logic [1:0]  typ;
    logic [2:0]  en;
    logic        last;
    logic [15:0] app;
    logic [15:0] mask;
    logic [31:0] rtag;
    logic [31:0] slba;
    logic [3:0]  nblk;
    logic [3:0]  kind;
    logic [3:0]  bad;
    logic [2:0]  st;
    logic        dnr;
  } vec_t;

  // kind: 0 clean, 1 guard flip, 2 app bit0 flip, 3 ref flip, 4 app=FFFF + bad guard/ref,
  //       5 app=FFFF ref=FFFFFFFF + bad guard, 6 app=FFFF only + bad guard, 7 guard and app flip
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 3'b111, 1'b1, 16'h1234, 16'hFFFF, 32'd100, 32'd100, 4'd2, 4'd0, 4'd0, 3'd0, 1'b0},
    '{2'd2, 3'b111, 1'b0, 16'hABCD, 16'hFF00, 32'd77,  32'd5,   4'd3, 4'd0, 4'd0, 3'd0, 1'b0},
    '{2'd1, 3'b111, 1'b1, 16'h1234, 16'hFFFF, 32'd8,   32'd8,   4'd3, 4'd1, 4'd2, 3'd1, 1'b0},
    '{2'd1, 3'b011, 1'b1, 16'h1234, 16'hFFFF, 32'd8,   32'd8,   4'd2, 4'd1, 4'd1, 3'd0, 1'b0},
    '{2'd2, 3'b111, 1'b0, 16'h1234, 16'h0F0F, 32'd40,  32'd0,   4'd2, 4'd2, 4'd1, 3'd2, 1'b0},
    '{2'd2, 3'b101, 1'b0, 16'h1234, 16'h0F0F, 32'd40,  32'd0,   4'd2, 4'd2, 4'd1, 3'd0, 1'b0},
    '{2'd1, 3'b111, 1'b1, 16'h0042, 16'hFFFF, 32'd300, 32'd300, 4'd3, 4'd3, 4'd3, 3'd3, 1'b0},
    '{2'd1, 3'b110, 1'b1, 16'h0042, 16'hFFFF, 32'd300, 32'd300, 4'd3, 4'd3, 4'd3, 3'd0, 1'b0},
    '{2'd1, 3'b111, 1'b0, 16'h0042, 16'hFFFF, 32'd9,   32'd9,   4'd1, 4'd4, 4'd0, 3'd0, 1'b0},
    '{2'd3, 3'b110, 1'b1, 16'h0777, 16'hFFFF, 32'd55,  32'd1,   4'd2, 4'd5, 4'd1, 3'd0, 1'b0},
    '{2'd3, 3'b110, 1'b1, 16'h0777, 16'hFFFF, 32'd55,  32'd1,   4'd2, 4'd6, 4'd1, 3'd1, 1'b0},
    '{2'd1, 3'b111, 1'b0, 16'h0101, 16'hFFFF, 32'd20,  32'd20,  4'd1, 4'd7, 4'd1, 3'd1, 1'b0},
    '{2'd1, 3'b111, 1'b1, 16'h0101, 16'hFFFF, 32'd10,  32'd11,  4'd1, 4'd0, 4'd0, 3'd4, 1'b1},
    '{2'd3, 3'b001, 1'b0, 16'h0101, 16'hFFFF, 32'd10,  32'd10,  4'd1, 4'd0, 4'd0, 3'd4, 1'b0},
    '{2'd2, 3'b111, 1'b1, 16'h0101, 16'hFFFF, 32'd50,  32'd999, 4'd1, 4'd0, 4'd0, 3'd0, 1'b0},
    '{2'd3, 3'b110, 1'b0, 16'h0202, 16'hFFFF, 32'd7,   32'd7,   4'd3, 4'd0, 4'd0, 3'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  typ = '0;
  logic [2:0]  en = '0;
  logic        tlast = 1'b0;
  logic [15:0] app = '0, mask = '0;
  logic [31:0] rtag = '0, slba = '0;
  logic [7:0]  nblk = '0;
  logic        bvalid = 1'b0;
  logic [7:0]  bdata = '0;
  logic        done;
  logic [2:0]  status;
  logic        dnr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pi_tuple_checker #(.DATA_BYTES(DATA_BYTES), .META_BYTES(META_BYTES), .NB_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .prot_type_i(typ), .chk_en_i(en),
    .tuple_last_i(tlast), .app_tag_i(app), .app_mask_i(mask), .ref_tag_i(rtag),
    .slba_i(slba), .num_blk_i(nblk), .byte_valid_i(bvalid), .byte_i(bdata),
    .done_o(done), .status_o(status), .dnr_o(dnr)
  );

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb;
      fb = r[15] ^ b[7-k];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h8BB7;
    end
    return r;
  endfunction

  function automatic string tag_of(input vec_t t);
    if (t.st == 3'd4) return (t.typ == 2'd1) ? "R1" : "R2";
    case (t.kind)
      4'd1:    return (t.st == 3'd0) ? "R11" : "R8";
      4'd2:    return (t.st == 3'd0) ? "R11" : "R6";
      4'd3:    return (t.st == 3'd0) ? "R11" : "R7";
      4'd4:    return "R3";
      4'd5, 4'd6: return "R4";
      4'd7:    return "R5";
      default: return (t.mask != 16'hFFFF) ? "R6" : "R7";
    endcase
  endfunction

  task automatic check(input string tag, input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, inout int ndone, input bit want,
                      input vec_t t, input string tag);
    @(negedge clk);
    start  = 1'b0;
    bvalid = 1'b1;
    bdata  = d;
    @(posedge clk);
    #1;
    if (done) ndone++;
    if (want) begin
      check("R12", done == 1'b1, "done at deciding byte", int'(done), 1);
      check(tag, status == t.st, "status", int'(status), int'(t.st));
      check(tag, dnr == t.dnr, "dnr", int'(dnr), int'(t.dnr));
    end
  endtask

  task automatic gap(inout int ndone);
    @(negedge clk);
    start  = 1'b0;
    bvalid = 1'b0;
    @(posedge clk);
    #1;
    if (done) ndone++;
  endtask

  task automatic run_vec(input vec_t t);
    int    ndone;
    int    dblk;
    string tag;
    ndone = 0;
    tag   = tag_of(t);
    dblk  = (t.st == 3'd0) ? int'(t.nblk) : int'(t.bad);
    @(negedge clk);
    start = 1'b1; typ = t.typ; en = t.en; tlast = t.last; app = t.app; mask = t.mask;
    rtag = t.rtag; slba = t.slba; nblk = {4'd0, t.nblk};
    @(posedge clk);
    #1;
    if (done) ndone++;
    if (t.st == 3'd4) begin
      check(tag, done == 1'b1, "pre-check done", int'(done), 1);
      check(tag, status == 3'd4, "pre-check status", int'(status), 4);
      check(tag, dnr == t.dnr, "pre-check dnr", int'(dnr), int'(t.dnr));
    end
    for (int b = 0; b <= int'(t.nblk); b++) begin
      logic [7:0]  buff [BLK];
      logic [15:0] g, a;
      logic [31:0] r;
      logic [63:0] tup;
      int          toff;
      g = '0;
      for (int i = 0; i < BLK; i++) buff[i] = 8'(b * 13 + i * 7 + int'(t.rtag) + 3);
      for (int i = 0; i < DATA_BYTES; i++) g = crc_step(g, buff[i]);
      if (t.last) for (int i = 0; i < PAD; i++) g = crc_step(g, buff[DATA_BYTES + i]);
      a = (t.app & t.mask) | (~t.mask & 16'h5A5A);
      r = (t.typ == 2'd3) ? t.rtag : t.rtag + 32'(b);
      if (b == int'(t.bad)) begin
        case (t.kind)
          4'd1: g = g ^ 16'h1;
          4'd2: a = a ^ 16'h1;
          4'd3: r = r ^ 32'h1;
          4'd4: begin a = 16'hFFFF; g = g ^ 16'h1; r = r ^ 32'h1; end
          4'd5: begin a = 16'hFFFF; r = 32'hFFFF_FFFF; g = g ^ 16'h1; end
          4'd6: begin a = 16'hFFFF; g = g ^ 16'h1; end
          4'd7: begin g = g ^ 16'h1; a = a ^ 16'h1; end
          default: ;
        endcase
      end
      tup  = {g, a, r};
      toff = t.last ? DATA_BYTES + PAD : DATA_BYTES;
      for (int k = 0; k < 8; k++) buff[toff + k] = tup[63 - 8*k -: 8];
      for (int i = 0; i < BLK; i++) begin
        if (i % 9 == 5) gap(ndone);
        push(buff[i], ndone, (t.st != 3'd4) && (b == dblk) && (i == BLK - 1), t, tag);
      end
    end
    gap(ndone);
    check("R9", ndone == 1, "done pulses per command", ndone, 1);
    if (t.st != 3'd0 && t.st != 3'd4 && dblk < int'(t.nblk))
      check("R10", status == t.st, "status held after drain", int'(status), int'(t.st));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nd;
    repeat (3) @(posedge clk);
    #1;
    check("R9", done == 1'b0, "reset done", int'(done), 0);
    check("R9", status == 3'd0, "reset status", int'(status), 0);
    check("R9", dnr == 1'b0, "reset dnr", int'(dnr), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) run_vec(VECS[v]);

    // R10: bytes with no open command produce nothing, and a following command is unaffected
    nd = 0;
    for (int i = 0; i < 12; i++) push(8'hFF, nd, 1'b0, VECS[0], "R10");
    gap(nd);
    check("R10", nd == 0, "done from idle bytes", nd, 0);
    run_vec(VECS[0]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule